// File: doc/BRIEF.md
# Image Sensor Power-Up and Streaming Sequencer

This block sits on the host side of a camera link and walks an image sensor from cold power-off to active streaming, and back to a standby state that keeps power on. It drives three supply-group enables in a fixed order: the I/O group first, then the core and transmit digital group, and last the PLL and analog/pixel group. The gap between consecutive groups is programmable in milliseconds. Once all three groups report power-good, the block turns on the sensor reference clock and holds the sensor's active-low reset. It releases that reset after a minimum time. It then waits out the sensor's internal start-up interval.

After start-up, an external configuration agent writes the PLL, output and image settings. The block asks for that work with a one-cycle `cfg_start` pulse and waits for `cfg_done`. It then raises the stream request and allows a fixed PLL lock time before it reports streaming. A stop request drops the stream request at once. The block counts the sensor as being in standby only when an end-of-row/frame pulse arrives. A later start skips the supply ramp and goes straight back to configuration. If the last supply group does not report good within a timeout, the block enters a sticky fault state and switches the groups off in reverse order, one per millisecond.

The states are OFF, RAMP_IO, RAMP_DIG, RAMP_ANA, CLK_ON, RESET, INIT, CONFIG, PLL_LOCK, STREAMING, STOPPING, STANDBY and FAULT. Each transition follows one rule:
- OFF to RAMP_IO on start. OFF goes to RAMP_DIG or RAMP_ANA instead when the leading gaps are zero.
- RAMP_IO to RAMP_DIG after the first gap. RAMP_IO goes to RAMP_ANA instead when the second gap is zero.
- RAMP_DIG to RAMP_ANA after the second gap.
- RAMP_ANA to CLK_ON when all power-good inputs are high, or to FAULT on timeout.
- CLK_ON to RESET after one cycle.
- RESET to INIT after the reset time.
- INIT to CONFIG after the start-up count.
- CONFIG to PLL_LOCK on `cfg_done`.
- PLL_LOCK to STREAMING after the lock time.
- STREAMING to STOPPING on stop.
- STOPPING to STANDBY on `frame_end`.
- STANDBY to CONFIG on start.
- FAULT is left only through `rst_n`.

Top module: `sensor_pwr_seq`

## Requirements
- R1: Supply enables nest. `en_dig` is never high without `en_io`, and `en_ana` is never high without `en_dig`. During ramp-up the groups come on in the order I/O, digital, analog.
- R2: With CLK_PER_MS system clocks per millisecond, a nonzero gap value g puts g*CLK_PER_MS+1 cycles between one group's enable and the next. A gap of 0 turns both groups on in the same cycle.
- R3: `refclk_en` rises only in the cycle after `pg_io`, `pg_dig` and `pg_ana` were all high.
- R4: `sensor_rst_n` is low from the rise of `refclk_en` until 1 + RST_MS*CLK_PER_MS+1 cycles later. This is never shorter than RST_MS milliseconds.
- R5: After `sensor_rst_n` rises, `cfg_start` pulses exactly INIT_REF_CYCLES*REF_DIV cycles later.
- R6: `cfg_start` is high for one cycle only. `stream_req` stays low until the cycle after `cfg_done` is seen in CONFIG.
- R7: `streaming` rises LOCK_MS*CLK_PER_MS+1 cycles after `stream_req` rises. `stream_req` stays high while streaming.
- R8: A stop request while streaming clears `stream_req` and `streaming` in the next cycle. The state stays STOPPING until `frame_end` is seen and becomes STANDBY in the next cycle. In STANDBY, supplies, clock and reset release all stay on.
- R9: `seq_state` encodes OFF=0, RAMP_IO=1, RAMP_DIG=2, RAMP_ANA=3, CLK_ON=4, RESET=5, INIT=6, CONFIG=7, PLL_LOCK=8, STREAMING=9, STOPPING=10, STANDBY=11, FAULT=12.
- R10: If power-good is still missing PG_TIMEOUT_MS*CLK_PER_MS+1 cycles after RAMP_ANA is entered, the block enters FAULT with `fault`=1 and `refclk_en`=0. In FAULT, `en_ana` is off at once, `en_dig` goes off one millisecond later, and `en_io` goes off one millisecond after that.
- R11: While `rst_n` is low and just after it is released, the state is OFF and every output is 0. This includes `sensor_rst_n`, so the sensor is held in reset.
- R12: `start_req` has no effect in any state other than OFF and STANDBY. From STANDBY, a start goes to CONFIG in the next cycle and pulses `cfg_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_req | input | 1 | Request to bring the sensor up to streaming |
| stop_req | input | 1 | Request to leave streaming |
| gap_io_dig_ms | input | GAP_W | Milliseconds from I/O enable to digital enable |
| gap_dig_ana_ms | input | GAP_W | Milliseconds from digital enable to analog enable |
| pg_io | input | 1 | I/O group power-good |
| pg_dig | input | 1 | Digital group power-good |
| pg_ana | input | 1 | Analog/PLL group power-good |
| cfg_done | input | 1 | Configuration agent finished |
| frame_end | input | 1 | End-of-row/frame pulse from the sensor |
| en_io | output | 1 | I/O supply enable |
| en_dig | output | 1 | Core and transmit digital supply enable |
| en_ana | output | 1 | PLL and analog/pixel supply enable |
| refclk_en | output | 1 | Sensor reference clock enable |
| sensor_rst_n | output | 1 | Active-low sensor reset |
| cfg_start | output | 1 | One-cycle request to the configuration agent |
| stream_req | output | 1 | Stream-mode request to the sensor |
| streaming | output | 1 | Sensor is streaming |
| fault | output | 1 | Power-good timeout fault |
| seq_state | output | 4 | Current state code |

## Verification
The ramp-up timing is driven with five gap pairs. The pairs are both zero, only the first zero, only the second zero, equal ones, and unequal values. They separate the one-cycle merge of a zero gap from the g*CLK_PER_MS+1 spacing, and they show whether each gap is applied to the correct pair of groups. One full bring-up then measures the reset width, the start-up count and the lock wait. During that run the configuration agent is held back for several cycles, which shows that `stream_req` waits for `cfg_done`. The stop path is driven with a late `frame_end` to show that standby waits for it. A restart from standby shows the direct return to CONFIG. A missing analog power-good shows the timeout and the reverse-order shutdown, and stray starts in STREAMING and FAULT show that they are ignored.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [3:0] {
        ST_OFF       = 4'd0,
        ST_RAMP_IO   = 4'd1,
        ST_RAMP_DIG  = 4'd2,
        ST_RAMP_ANA  = 4'd3,
        ST_CLK_ON    = 4'd4,
        ST_RESET     = 4'd5,
        ST_INIT      = 4'd6,
        ST_CONFIG    = 4'd7,
        ST_PLL_LOCK  = 4'd8,
        ST_STREAMING = 4'd9,
        ST_STOPPING  = 4'd10,
        ST_STANDBY   = 4'd11,
        ST_FAULT     = 4'd12
    } seq_state_t;
endpackage

// File: rtl/sps_ms_tick.sv
module sps_ms_tick #(
    parameter int CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = $clog2(CLK_PER_MS + 1);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre <= '0;
        else if (clr || pre == LAST)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    assign tick = (pre == LAST) && !clr;
endmodule

// File: rtl/sps_elapsed.sv
module sps_elapsed #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != {W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sensor_pwr_seq.sv
module sensor_pwr_seq
    import sps_pkg::*;
#(
    parameter int CLK_PER_MS      = 125000,
    parameter int GAP_W           = 9,
    parameter int PG_TIMEOUT_MS   = 500,
    parameter int RST_MS          = 1,
    parameter int LOCK_MS         = 1,
    parameter int INIT_REF_CYCLES = 2400,
    parameter int REF_DIV         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [GAP_W-1:0] gap_io_dig_ms,
    input  logic [GAP_W-1:0] gap_dig_ana_ms,
    input  logic             pg_io,
    input  logic             pg_dig,
    input  logic             pg_ana,
    input  logic             cfg_done,
    input  logic             frame_end,
    output logic             en_io,
    output logic             en_dig,
    output logic             en_ana,
    output logic             refclk_en,
    output logic             sensor_rst_n,
    output logic             cfg_start,
    output logic             stream_req,
    output logic             streaming,
    output logic             fault,
    output logic [3:0]       seq_state
);
    localparam int INIT_CLKS = INIT_REF_CYCLES * REF_DIV;
    localparam int CYC_W     = $clog2(INIT_CLKS + 1);
    localparam int MS_W      = GAP_W + 2;

    seq_state_t st, st_nxt;
    logic             st_change;
    logic             ms_tick;
    logic [MS_W-1:0]  ms_cnt;
    logic [CYC_W-1:0] cyc_cnt;
    logic             pg_all;

    assign pg_all    = pg_io && pg_dig && pg_ana;
    assign st_change = (st_nxt != st);

    sps_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(st_change), .tick(ms_tick)
    );

    sps_elapsed #(.W(MS_W)) u_ms_cnt (
        .clk(clk), .rst_n(rst_n), .clr(st_change), .inc(ms_tick), .cnt(ms_cnt)
    );

    sps_elapsed #(.W(CYC_W)) u_cyc_cnt (
        .clk(clk), .rst_n(rst_n), .clr(st_change), .inc(1'b1), .cnt(cyc_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_OFF;
        else
            st <= st_nxt;
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_OFF:
                if (start_req) begin
                    if (gap_io_dig_ms != '0)
                        st_nxt = ST_RAMP_IO;
                    else if (gap_dig_ana_ms != '0)
                        st_nxt = ST_RAMP_DIG;
                    else
                        st_nxt = ST_RAMP_ANA;
                end
            ST_RAMP_IO:
                if (ms_cnt >= MS_W'(gap_io_dig_ms))
                    st_nxt = (gap_dig_ana_ms == '0) ? ST_RAMP_ANA : ST_RAMP_DIG;
            ST_RAMP_DIG:
                if (ms_cnt >= MS_W'(gap_dig_ana_ms))
                    st_nxt = ST_RAMP_ANA;
            ST_RAMP_ANA:
                if (pg_all)
                    st_nxt = ST_CLK_ON;
                else if (ms_cnt >= MS_W'(PG_TIMEOUT_MS))
                    st_nxt = ST_FAULT;
            ST_CLK_ON:
                st_nxt = ST_RESET;
            ST_RESET:
                if (ms_cnt >= MS_W'(RST_MS))
                    st_nxt = ST_INIT;
            ST_INIT:
                if (cyc_cnt >= CYC_W'(INIT_CLKS - 1))
                    st_nxt = ST_CONFIG;
            ST_CONFIG:
                if (cfg_done)
                    st_nxt = ST_PLL_LOCK;
            ST_PLL_LOCK:
                if (ms_cnt >= MS_W'(LOCK_MS))
                    st_nxt = ST_STREAMING;
            ST_STREAMING:
                if (stop_req)
                    st_nxt = ST_STOPPING;
            ST_STOPPING:
                if (frame_end)
                    st_nxt = ST_STANDBY;
            ST_STANDBY:
                if (start_req)
                    st_nxt = ST_CONFIG;
            ST_FAULT:
                st_nxt = ST_FAULT;
            default:
                st_nxt = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        en_io        = 1'b0;
        en_dig       = 1'b0;
        en_ana       = 1'b0;
        refclk_en    = 1'b0;
        sensor_rst_n = 1'b0;
        stream_req   = 1'b0;
        streaming    = 1'b0;
        fault        = 1'b0;
        cfg_start    = 1'b0;
        unique case (st)
            ST_OFF: ;
            ST_RAMP_IO:
                en_io = 1'b1;
            ST_RAMP_DIG: begin
                en_io  = 1'b1;
                en_dig = 1'b1;
            end
            ST_RAMP_ANA: begin
                en_io  = 1'b1;
                en_dig = 1'b1;
                en_ana = 1'b1;
            end
            ST_CLK_ON, ST_RESET: begin
                en_io     = 1'b1;
                en_dig    = 1'b1;
                en_ana    = 1'b1;
                refclk_en = 1'b1;
            end
            ST_INIT, ST_CONFIG, ST_STOPPING, ST_STANDBY: begin
                en_io        = 1'b1;
                en_dig       = 1'b1;
                en_ana       = 1'b1;
                refclk_en    = 1'b1;
                sensor_rst_n = 1'b1;
                cfg_start    = (st == ST_CONFIG) && (cyc_cnt == '0);
            end
            ST_PLL_LOCK, ST_STREAMING: begin
                en_io        = 1'b1;
                en_dig       = 1'b1;
                en_ana       = 1'b1;
                refclk_en    = 1'b1;
                sensor_rst_n = 1'b1;
                stream_req   = 1'b1;
                streaming    = (st == ST_STREAMING);
            end
            ST_FAULT: begin
                fault  = 1'b1;
                en_io  = (ms_cnt < MS_W'(2));
                en_dig = (ms_cnt < MS_W'(1));
            end
            default: ;
        endcase
    end

    assign seq_state = st;

    // Assertions
    assert_dig_needs_io_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_dig |-> en_io);
    assert_ana_needs_dig_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_ana |-> en_dig);
    assert_clk_after_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refclk_en) |-> $past(pg_io && pg_dig && pg_ana));

    logic [31:0] rst_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rst_low_cnt <= '0;
        else if (!refclk_en)
            rst_low_cnt <= '0;
        else if (!sensor_rst_n && rst_low_cnt != 32'hFFFF_FFFF)
            rst_low_cnt <= rst_low_cnt + 1;
    end
    assert_rst_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sensor_rst_n) |-> (rst_low_cnt >= 32'(RST_MS * CLK_PER_MS)));

    assert_cfg_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start);
    assert_stream_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_req) |-> $past(cfg_done));
    assert_standby_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STANDBY && $past(st) == ST_STOPPING) |-> $past(frame_end));
    assert_fault_clk_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!refclk_en && !en_ana));
    assert_standby_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STANDBY && start_req) |=> (st == ST_CONFIG));
endmodule

// File: tb/tb_sensor_pwr_seq.sv
module tb_sensor_pwr_seq;
    localparam int P    = 4;
    localparam int GW   = 9;
    localparam int TO   = 5;
    localparam int RSTM = 1;
    localparam int LCKM = 1;
    localparam int IREF = 6;
    localparam int RDIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic [GW-1:0] gap1 = '0, gap2 = '0;
    logic pg_io = 1'b1, pg_dig = 1'b1, pg_ana = 1'b1;
    logic cfg_done = 1'b0, frame_end = 1'b0;
    logic en_io, en_dig, en_ana, refclk_en, sensor_rst_n;
    logic cfg_start, stream_req, streaming, fault;
    logic [3:0] seq_state;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sensor_pwr_seq #(
        .CLK_PER_MS(P), .GAP_W(GW), .PG_TIMEOUT_MS(TO), .RST_MS(RSTM),
        .LOCK_MS(LCKM), .INIT_REF_CYCLES(IREF), .REF_DIV(RDIV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .gap_io_dig_ms(gap1), .gap_dig_ana_ms(gap2),
        .pg_io(pg_io), .pg_dig(pg_dig), .pg_ana(pg_ana),
        .cfg_done(cfg_done), .frame_end(frame_end),
        .en_io(en_io), .en_dig(en_dig), .en_ana(en_ana), .refclk_en(refclk_en),
        .sensor_rst_n(sensor_rst_n), .cfg_start(cfg_start), .stream_req(stream_req),
        .streaming(streaming), .fault(fault), .seq_state(seq_state)
    );

    typedef struct packed {
        logic [8:0] g1;
        logic [8:0] g2;
    } vec_t;
    localparam vec_t VECS [5] = '{
        '{g1: 9'd0, g2: 9'd0},
        '{g1: 9'd0, g2: 9'd3},
        '{g1: 9'd2, g2: 9'd0},
        '{g1: 9'd1, g2: 9'd1},
        '{g1: 9'd3, g2: 9'd2}
    };

    function automatic int sep(input int g);
        return (g == 0) ? 0 : g * P + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_req = 1'b0; stop_req = 1'b0; cfg_done = 1'b0; frame_end = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        // R2 / R1: ramp spacing table
        foreach (VECS[i]) begin
            gap1 = VECS[i].g1;
            gap2 = VECS[i].g2;
            do_reset();
            pulse_start();
            n = 0;
            while (!en_dig && n < 1000) begin @(negedge clk); n++; end
            chk(n == sep(int'(VECS[i].g1)) && en_io, "R2 io->dig", n, sep(int'(VECS[i].g1)));
            n = 0;
            while (!en_ana && n < 1000) begin @(negedge clk); n++; end
            chk(n == sep(int'(VECS[i].g2)) && en_dig && en_io, "R1 R2 dig->ana", n, sep(int'(VECS[i].g2)));
        end

        // R11: reset state
        rst_n = 1'b0;
        @(negedge clk);
        chk(seq_state == 4'd0 && !en_io && !en_dig && !en_ana && !refclk_en && !sensor_rst_n
            && !cfg_start && !stream_req && !streaming && !fault, "R11 in reset", seq_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seq_state == 4'd0 && !en_io && !sensor_rst_n, "R11 after reset", seq_state, 0);

        // Full bring-up with gaps 1/1
        gap1 = 9'd1; gap2 = 9'd1;
        pulse_start();
        chk(seq_state == 4'd1, "R9 RAMP_IO code", seq_state, 1);
        n = 0;
        while (!refclk_en && n < 1000) begin @(negedge clk); n++; end
        chk(seq_state == 4'd4 && !sensor_rst_n, "R3 R9 CLK_ON", seq_state, 4);
        n = 0;
        while (!sensor_rst_n && n < 1000) begin @(negedge clk); n++; end
        chk(n == 1 + RSTM * P + 1, "R4 reset width", n, 1 + RSTM * P + 1);
        n = 0;
        while (!cfg_start && n < 1000) begin @(negedge clk); n++; end
        chk(n == IREF * RDIV && seq_state == 4'd7, "R5 init wait", n, IREF * RDIV);
        @(negedge clk);
        chk(!cfg_start, "R6 single pulse", cfg_start, 0);
        repeat (4) @(negedge clk);
        chk(!stream_req && seq_state == 4'd7, "R6 waits for done", stream_req, 0);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        chk(stream_req && seq_state == 4'd8, "R6 stream after done", seq_state, 8);
        n = 0;
        while (!streaming && n < 1000) begin @(negedge clk); n++; end
        chk(n == LCKM * P + 1 && stream_req && seq_state == 4'd9, "R7 lock wait", n, LCKM * P + 1);

        // R12: start ignored while streaming
        pulse_start();
        chk(seq_state == 4'd9 && streaming, "R12 start ignored", seq_state, 9);

        // R8: stop handshake
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(!stream_req && !streaming && seq_state == 4'd10, "R8 stop clears", seq_state, 10);
        repeat (6) @(negedge clk);
        chk(seq_state == 4'd10, "R8 waits frame_end", seq_state, 10);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        chk(seq_state == 4'd11 && en_ana && refclk_en && sensor_rst_n, "R8 standby", seq_state, 11);

        // R12: restart from standby
        pulse_start();
        chk(seq_state == 4'd7 && cfg_start && en_io, "R12 standby to config", seq_state, 7);

        // R10: power-good timeout and unwinding
        gap1 = 9'd0; gap2 = 9'd0; pg_ana = 1'b0;
        do_reset();
        pulse_start();
        chk(seq_state == 4'd3 && en_ana, "R2 R9 all together", seq_state, 3);
        n = 0;
        while (!fault && n < 1000) begin @(negedge clk); n++; end
        chk(n == TO * P + 1, "R10 timeout", n, TO * P + 1);
        chk(seq_state == 4'd12 && !en_ana && en_dig && en_io && !refclk_en, "R10 R3 ana off first", seq_state, 12);
        repeat (P) @(negedge clk);
        chk(!en_dig && en_io, "R10 dig off second", en_dig, 0);
        pulse_start();
        repeat (P - 1) @(negedge clk);
        chk(!en_io && seq_state == 4'd12 && fault, "R10 R12 io off, start ignored", seq_state, 12);
        pg_ana = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule